// File: doc/BRIEF.md
# Programmable USART Channel

This block is one full-duplex asynchronous serial channel. The transmitter takes bytes from a two-entry write buffer and frames them. The receiver deframes the incoming line and stores each character in a four-entry FIFO. Each stored character carries its own parity-error and framing-error flags. Each side runs either from a shared 16x oversampling tick or from its own external bit-rate (1x) strobe. All strobes are single-cycle enables in the `clk` domain.

The character format is set from ports. The data length is 5 to 8 bits, sent least significant bit first. Parity is even, odd or absent. The stop time is set in sixteenths of a bit. Modem-style flow control holds off new transmissions while `cts` is low, and drops `rts` while the receive FIFO is full. A loop selector picks one of four routings: normal, automatic echo, local loopback, or remote loopback.

Top module: `usart_channel`

## Requirements
- R1: `char_len` code n (0..3) selects n+5 data bits. Data bits go out after the start bit, least significant bit first. The receiver returns them right-aligned, with the unused upper bits zero.
- R2: `par_sel` 01 selects even parity and 10 selects odd parity; 00 and 11 select no parity bit. The parity bit follows the last data bit and makes the count of ones in data plus parity even (01) or odd (10). A received mismatch sets `rx_par_err` for that character.
- R3: In 16x mode the line stays high for `stop_len`+1 ticks between the last data or parity bit and the next start bit when characters are queued. In 1x mode the stop time is 2 bit times when `stop_len[4]` is 1, and 1 bit time otherwise.
- R4: In 16x mode each bit lasts 16 ticks. The receiver re-checks a falling edge 8 ticks after seeing it, and drops the start bit if the line is high at that point.
- R5: With `tx_ext_mode` or `rx_ext_mode` set, that side uses its external strobe, at one strobe per bit.
- R6: The receive FIFO holds 4 characters. A character completing while it is full, with no pop in that cycle, is dropped and sets `rx_overrun`. The flag stays set until `overrun_clr`.
- R7: A low stop bit at mid-bit sets `rx_frm_err` for that character. The data is still stored.
- R8: The transmit buffer holds 2 bytes, and `tx_ready` is low while it is full. A write when full is dropped, unless the transmitter takes a byte in the same cycle; then the write is accepted.
- R9: The transmitter starts no character while `cts` is low. A character already started is sent to the end.
- R10: `rts` is low exactly while the receive FIFO is full.
- R11: `loop_sel` 01 (automatic echo): `txd` follows `rxd`, and the receiver still stores the incoming characters.
- R12: `loop_sel` 10 (local loopback): the receiver sees the transmitter output, and `txd` stays high.
- R13: `loop_sel` 11 (remote loopback): `txd` follows `rxd`, and the receiver stores nothing.
- R14: After reset, `txd` and `rts` are high, `tx_ready` is high, and `rx_avail` and `rx_overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick16 | input | 1 | 16x oversampling strobe |
| tx_ext_mode | input | 1 | Transmitter uses external 1x strobe |
| tx_ext_tick | input | 1 | Transmitter 1x strobe |
| rx_ext_mode | input | 1 | Receiver uses external 1x strobe |
| rx_ext_tick | input | 1 | Receiver 1x strobe |
| char_len | input | 2 | Data bits minus 5 |
| par_sel | input | 2 | Parity select |
| stop_len | input | 5 | Stop time code |
| loop_sel | input | 2 | Routing mode |
| tx_byte | input | 8 | Byte to send |
| tx_push | input | 1 | Write strobe for tx_byte |
| tx_ready | output | 1 | Transmit buffer has room |
| rx_avail | output | 1 | Receive FIFO not empty |
| rx_byte | output | 8 | Oldest received character |
| rx_par_err | output | 1 | Parity error of rx_byte |
| rx_frm_err | output | 1 | Framing error of rx_byte |
| rx_pop | input | 1 | Remove oldest character |
| rx_overrun | output | 1 | Sticky overrun flag |
| overrun_clr | input | 1 | Clears rx_overrun |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |
| cts | input | 1 | Clear to send, active high |
| rts | output | 1 | Ready to receive, active high |

## Verification
Two actions can land on one edge: the transmitter pulling a byte from a full buffer, and a new write to that buffer. The bench stalls the 16x tick and holds `cts` low to fill the buffer, and checks that a lone extra write is dropped. It then raises `cts`, the tick and a write on the same edge. It judges the result by reading back, through local loopback, exactly the three accepted bytes in order and not the dropped one.

// File: rtl/usart_channel.sv
module usart_channel #(
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       tx_ext_mode,
  input  logic       tx_ext_tick,
  input  logic       rx_ext_mode,
  input  logic       rx_ext_tick,
  input  logic [1:0] char_len,
  input  logic [1:0] par_sel,
  input  logic [4:0] stop_len,
  input  logic [1:0] loop_sel,
  input  logic [7:0] tx_byte,
  input  logic       tx_push,
  output logic       tx_ready,
  output logic       rx_avail,
  output logic [7:0] rx_byte,
  output logic       rx_par_err,
  output logic       rx_frm_err,
  input  logic       rx_pop,
  output logic       rx_overrun,
  input  logic       overrun_clr,
  input  logic       rxd,
  output logic       txd,
  input  logic       cts,
  output logic       rts
);
  localparam int RAW = $clog2(RX_DEPTH);
  localparam int TAW = $clog2(TX_DEPTH);
  localparam logic [RAW:0] RQ_FULL = RX_DEPTH[RAW:0];
  localparam logic [TAW:0] TQ_FULL = TX_DEPTH[TAW:0];

  typedef enum logic [1:0] {R_IDLE, R_START, R_DATA, R_STOP} rx_state_t;

  wire       pen   = par_sel == 2'b01 || par_sel == 2'b10;
  wire       podd  = par_sel == 2'b10;
  wire [3:0] dbits = {2'b00, char_len} + 4'd5;
  wire [7:0] dmask = 8'hFF >> (2'd3 - char_len);

  // transmit buffer
  logic [7:0]   tq [TX_DEPTH];
  logic [TAW-1:0] tq_rd, tq_wr;
  logic [TAW:0] tq_cnt;
  logic         tx_load;
  wire          tq_acc = tx_push && (tq_cnt != TQ_FULL || tx_load);
  assign tx_ready = tq_cnt != TQ_FULL;

  always_ff @(posedge clk) if (tq_acc) tq[tq_wr] <= tx_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tq_rd <= '0; tq_wr <= '0; tq_cnt <= '0;
    end else begin
      if (tq_acc) tq_wr <= tq_wr + 1'b1;
      if (tx_load) tq_rd <= tq_rd + 1'b1;
      tq_cnt <= tq_cnt + (TAW+1)'(tq_acc) - (TAW+1)'(tx_load);
    end

  // transmitter
  wire       tx_en     = tx_ext_mode ? tx_ext_tick : tick16;
  wire [4:0] tx_bit_t  = tx_ext_mode ? 5'd0 : 5'd15;
  wire [4:0] tx_stop_t = tx_ext_mode ? {4'd0, stop_len[4]} : stop_len;
  logic       tx_busy, tx_stop;
  logic [4:0] tx_cnt;
  logic [3:0] tx_left;
  logic [9:0] tx_sh, frame;
  wire  [7:0] tx_d = tq[tq_rd] & dmask;

  always_comb begin
    frame = {1'b1, tx_d, 1'b0};
    frame[dbits + 4'd1] = pen ? (^tx_d ^ podd) : 1'b1;
  end

  assign tx_load = tx_en && (!tx_busy || (tx_stop && tx_cnt == 5'd0)) && tq_cnt != '0 && cts;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0; tx_stop <= 1'b0; tx_cnt <= '0; tx_left <= '0; tx_sh <= '1;
    end else if (tx_load) begin
      tx_busy <= 1'b1; tx_stop <= 1'b0; tx_cnt <= tx_bit_t;
      tx_left <= dbits + {3'b000, pen} + 4'd1;
      tx_sh   <= frame;
    end else if (tx_en && tx_busy) begin
      if (tx_cnt != 5'd0) tx_cnt <= tx_cnt - 5'd1;
      else if (!tx_stop) begin
        if (tx_left > 4'd1) begin
          tx_sh <= {1'b1, tx_sh[9:1]}; tx_left <= tx_left - 4'd1; tx_cnt <= tx_bit_t;
        end else begin
          tx_stop <= 1'b1; tx_cnt <= tx_stop_t;
        end
      end else tx_busy <= 1'b0;
    end

  wire tx_line = (tx_busy && !tx_stop) ? tx_sh[0] : 1'b1;

  // routing
  wire rx_src = loop_sel == 2'b10 ? tx_line : loop_sel == 2'b11 ? 1'b1 : rxd;
  assign txd  = loop_sel == 2'b00 ? tx_line : loop_sel == 2'b10 ? 1'b1 : rxd;

  // receiver
  logic [1:0] rx_sy;
  rx_state_t  rx_st;
  logic [3:0] rx_cnt, rx_got;
  logic [8:0] rx_sh;
  wire        rx_in   = rx_sy[1];
  wire        rx_en   = rx_ext_mode ? rx_ext_tick : tick16;
  wire [3:0]  rx_bit_t = rx_ext_mode ? 4'd0 : 4'd15;
  wire [3:0]  rx_need = dbits + {3'b000, pen};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_sy <= 2'b11; rx_st <= R_IDLE; rx_cnt <= '0; rx_got <= '0; rx_sh <= '0;
    end else begin
      rx_sy <= {rx_sy[0], rx_src};
      if (rx_en)
        case (rx_st)
          R_IDLE: if (!rx_in) begin
            rx_got <= '0;
            if (rx_ext_mode) begin rx_st <= R_DATA; rx_cnt <= 4'd0; end
            else begin rx_st <= R_START; rx_cnt <= 4'd7; end
          end
          R_START:
            if (rx_cnt != 4'd0) rx_cnt <= rx_cnt - 4'd1;
            else if (rx_in) rx_st <= R_IDLE;
            else begin rx_st <= R_DATA; rx_cnt <= rx_bit_t; end
          R_DATA:
            if (rx_cnt != 4'd0) rx_cnt <= rx_cnt - 4'd1;
            else begin
              rx_sh <= {rx_in, rx_sh[8:1]}; rx_got <= rx_got + 4'd1; rx_cnt <= rx_bit_t;
              if (rx_got + 4'd1 == rx_need) rx_st <= R_STOP;
            end
          default:
            if (rx_cnt != 4'd0) rx_cnt <= rx_cnt - 4'd1;
            else rx_st <= R_IDLE;
        endcase
    end

  wire [8:0] rx_al   = rx_sh >> (4'd9 - rx_need);
  wire [7:0] rx_d    = rx_al[7:0] & dmask;
  wire       rx_perr = pen && ((^rx_d ^ rx_al[dbits]) != podd);

  // receive FIFO
  logic [9:0]     rq [RX_DEPTH];
  logic [RAW-1:0] rq_rd, rq_wr;
  logic [RAW:0]   rq_cnt;
  wire rq_push = rx_en && rx_st == R_STOP && rx_cnt == 4'd0;
  wire rq_pop  = rx_pop && rq_cnt != '0;
  wire rq_acc  = rq_push && (rq_cnt != RQ_FULL || rq_pop);

  always_ff @(posedge clk) if (rq_acc) rq[rq_wr] <= {!rx_in, rx_perr, rx_d};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rq_rd <= '0; rq_wr <= '0; rq_cnt <= '0; rx_overrun <= 1'b0;
    end else begin
      if (rq_acc) rq_wr <= rq_wr + 1'b1;
      if (rq_pop) rq_rd <= rq_rd + 1'b1;
      rq_cnt <= rq_cnt + (RAW+1)'(rq_acc) - (RAW+1)'(rq_pop);
      rx_overrun <= (rx_overrun && !overrun_clr) || (rq_push && !rq_acc);
    end

  assign rx_avail = rq_cnt != '0;
  assign {rx_frm_err, rx_par_err, rx_byte} = rq[rq_rd];
  assign rts = rq_cnt != RQ_FULL;

  assert_cts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && !cts) |=> !tx_busy);
  assert_start_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st == R_START && rx_en && rx_cnt == 4'd0 && rx_in) |=> rx_st == R_IDLE);
  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overrun && !overrun_clr) |=> rx_overrun);
  assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts && !rx_pop) |=> !rts);
  assert_remote_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_st == R_IDLE && loop_sel == 2'b11 && rx_sy == 2'b11) |=> rx_st == R_IDLE);
  assert_txbuf_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_ready && !tx_load) |=> !tx_ready);
endmodule

// File: tb/test_usart_channel.sv
module test_usart_channel;
  logic clk = 0, rst_n = 0;
  logic tick16 = 1, tx_ext_mode = 0, tx_ext_tick = 1, rx_ext_mode = 0, rx_ext_tick = 1;
  logic [1:0] char_len = 3, par_sel = 0, loop_sel = 0;
  logic [4:0] stop_len = 15;
  logic [7:0] tx_byte = 0;
  logic tx_push = 0, rx_pop = 0, overrun_clr = 0, rxd = 1, cts = 1;
  logic tx_ready, rx_avail, rx_par_err, rx_frm_err, rx_overrun, txd, rts;
  logic [7:0] rx_byte;
  int checks = 0, errors = 0, echo_bad = 0;
  bit mon_echo = 0;

  always #2.5 clk = ~clk;

  usart_channel i_usart_channel (.*);

  // {ext, par, len, data}
  localparam int NV = 8;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd3, 8'hA5}, {1'b0, 2'd1, 2'd2, 8'h5A},
    {1'b0, 2'd2, 2'd1, 8'h13}, {1'b0, 2'd1, 2'd0, 8'h1F},
    {1'b1, 2'd2, 2'd3, 8'hC3}, {1'b1, 2'd0, 2'd0, 8'h2D},
    {1'b1, 2'd1, 2'd2, 8'h7E}, {1'b0, 2'd1, 2'd3, 8'hFF}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_echo) begin #1; if (txd !== rxd) echo_bad++; end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask

  task automatic push(input logic [7:0] b);
    tx_byte = b; tx_push = 1; cyc(1); tx_push = 0;
  endtask

  task automatic pop; rx_pop = 1; cyc(1); rx_pop = 0; endtask

  task automatic wait_avail(input int lim);
    for (int i = 0; i < lim && !rx_avail; i++) cyc(1);
  endtask

  task automatic wait_fall(input int lim);
    for (int i = 0; i < lim && txd !== 1'b0; i++) cyc(1);
  endtask

  task automatic run_len(input logic lvl, output int n);
    n = 0;
    while (txd === lvl && n < 1000) begin n++; cyc(1); end
  endtask

  task automatic drive(input logic b, input int n); rxd = b; cyc(n); endtask

  task automatic send_rx(input logic [7:0] d, input int nd, input bit pe, input bit po,
                         input bit badp, input bit badstop);
    logic [7:0] m;
    m = 8'hFF >> (8 - nd);
    drive(0, 16);
    for (int i = 0; i < nd; i++) drive(d[i], 16);
    if (pe) drive((^(d & m)) ^ po ^ badp, 16);
    if (badstop) begin drive(0, 12); drive(1, 20); end
    else drive(1, 16);
    drive(1, 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi;
    logic [9:0] cap;
    cyc(3);
    chk("R14 txd", txd, 1); chk("R14 rts", rts, 1); chk("R14 tx_ready", tx_ready, 1);
    chk("R14 rx_avail", rx_avail, 0); chk("R14 overrun", rx_overrun, 0);
    rst_n = 1; cyc(2);

    // vector table via local loopback (R1, R2, R5, R12)
    loop_sel = 2'b10;
    for (int v = 0; v < NV; v++) begin
      {tx_ext_mode, par_sel, char_len} = VEC[v][12:8];
      rx_ext_mode = tx_ext_mode;
      push(VEC[v][7:0]);
      wait_avail(400);
      chk($sformatf("R1 R5 R12 vec%0d data", v), rx_byte, VEC[v][7:0] & (8'hFF >> (3 - VEC[v][9:8])));
      chk($sformatf("R2 vec%0d perr", v), {rx_par_err, rx_frm_err, txd}, 3'b001);
      pop; cyc(40);
    end
    tx_ext_mode = 0; rx_ext_mode = 0;

    // waveform: 7 bits even then odd (R1, R2)
    loop_sel = 0; char_len = 2;
    for (int k = 0; k < 2; k++) begin
      par_sel = k ? 2'b10 : 2'b01;
      push(8'h35); wait_fall(50); cyc(8);
      for (int b = 0; b < 10; b++) begin cap[b] = txd; if (b < 9) cyc(16); end
      chk("R1 lsb-first data", cap[7:1], 7'h35);
      chk("R2 parity bit", cap[8], k);
      chk("R1 start/stop", {cap[9], cap[0]}, 2'b10);
      cyc(40);
    end

    // stop length (R3)
    char_len = 3; par_sel = 0; stop_len = 23;
    push(0); push(0); wait_fall(50);
    run_len(0, lo); run_len(1, hi);
    chk("R4 bit time 16x", lo, 144); chk("R3 stop 16x", hi, 24);
    cyc(300);
    tx_ext_mode = 1; stop_len = 16;
    push(0); push(0); wait_fall(50);
    run_len(0, lo); run_len(1, hi);
    chk("R5 bit time 1x", lo, 9); chk("R3 stop 1x", hi, 2);
    cyc(50); tx_ext_mode = 0; stop_len = 15;

    // CTS (R9)
    cts = 0; push(0); hi = 0;
    for (int i = 0; i < 200; i++) begin if (txd !== 1) hi++; cyc(1); end
    chk("R9 held by cts", hi, 0);
    cts = 1; wait_fall(5); cyc(20); cts = 0;
    run_len(0, lo);
    chk("R9 in-progress completes", lo, 144 - 20);
    cyc(30); push(0); hi = 0;
    for (int i = 0; i < 200; i++) begin if (txd !== 1) hi++; cyc(1); end
    chk("R9 no new start", hi, 0);
    cts = 1; cyc(250);

    // glitch rejection (R4)
    drive(0, 4); drive(1, 40);
    chk("R4 short start rejected", rx_avail, 0);

    // framing and parity errors (R7, R2)
    send_rx(8'h6C, 8, 0, 0, 0, 1);
    chk("R7 frm flag", {rx_avail, rx_frm_err, rx_par_err}, 3'b110);
    chk("R7 data kept", rx_byte, 8'h6C); pop;
    par_sel = 2'b01;
    send_rx(8'h6C, 8, 1, 0, 1, 0);
    chk("R2 rx parity error", {rx_avail, rx_par_err, rx_frm_err}, 3'b110); pop;
    send_rx(8'h6D, 8, 1, 0, 0, 0);
    chk("R2 rx parity ok", {rx_byte, rx_par_err}, {8'h6D, 1'b0}); pop;
    par_sel = 0;

    // overrun and RTS (R6, R10)
    for (int i = 0; i < 4; i++) send_rx(8'h40 + 8'(i), 8, 0, 0, 0, 0);
    chk("R10 rts low when full", {rts, rx_overrun}, 2'b00);
    send_rx(8'h99, 8, 0, 0, 0, 0);
    chk("R6 overrun set", rx_overrun, 1);
    for (int i = 0; i < 4; i++) begin
      chk("R6 kept order", rx_byte, 8'h40 + 8'(i)); pop;
      if (i == 0) chk("R10 rts back", rts, 1);
    end
    chk("R6 dropped char absent", rx_avail, 0);
    chk("R6 sticky", rx_overrun, 1);
    overrun_clr = 1; cyc(1); overrun_clr = 0;
    chk("R6 clear", rx_overrun, 0);

    // automatic echo (R11)
    loop_sel = 2'b01; mon_echo = 1; echo_bad = 0;
    send_rx(8'hB2, 8, 0, 0, 0, 0);
    mon_echo = 0;
    chk("R11 txd follows rxd", echo_bad, 0);
    chk("R11 receiver still stores", {rx_avail, rx_byte}, {1'b1, 8'hB2}); pop;

    // remote loopback (R13)
    loop_sel = 2'b11; mon_echo = 1; echo_bad = 0;
    send_rx(8'hB3, 8, 0, 0, 0, 0);
    mon_echo = 0;
    chk("R13 txd follows rxd", echo_bad, 0);
    chk("R13 receiver silent", rx_avail, 0);

    // buffer full write coinciding with transmitter pull (R8)
    loop_sel = 2'b10; tick16 = 0; cts = 0; cyc(2);
    push(8'h11); push(8'h22);
    chk("R8 full", tx_ready, 0);
    push(8'h44);
    tick16 = 1; cts = 1; tx_byte = 8'h33; tx_push = 1; cyc(1); tx_push = 0;
    chk("R8 still full after pull+write", tx_ready, 0);
    wait_avail(400); chk("R8 first", rx_byte, 8'h11); pop;
    wait_avail(400); chk("R8 second", rx_byte, 8'h22); pop;
    wait_avail(400); chk("R8 coincident write kept", rx_byte, 8'h33); pop;
    cyc(400);
    chk("R8 dropped write absent", rx_avail, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule